// File: doc/BRIEF.md
# Time-of-Day Link Receive Channel

This block is one receive channel of a serial time-of-day distribution link. A recovered bit stream arrives one bit per strobe, most significant bit of each symbol first. The channel first hunts for symbol alignment by sliding a 16-bit window one bit at a time. It declares lock once it has seen a run of idle symbols spaced exactly 16 bits apart. Once locked, it cuts the stream into 16-bit symbols and sorts each one into idle, frame start, data byte, check, or on-time.

A frame is a frame-start symbol, then up to eight data bytes, then a check symbol that carries the XOR of those bytes. The first frame whose check matches is kept, and every later repeat of the frame is dropped. A frame that fails is discarded, and the channel waits for the next repeat. When the on-time symbol arrives, the channel publishes the kept bytes, or a status saying why it has none. If no on-time symbol arrives within a configurable number of bit strobes, the channel publishes a timeout status instead. That status tells apart a channel that never locked from one that is locked but missed its marker.

The bit input has no ready signal, because a recovered line cannot be stalled. Results leave on a valid/ready port. A result stays on the port, unchanged, until `out_ready` is seen high at a clock edge. A new result that arrives while an older one is still waiting replaces it, so the consumer sees only the most recent cause.

Top module: `tref_rx_chan`

## Requirements
- R1: Bits sampled on `bit_valid` shift into a 16-bit symbol MSB first. The symbol codes are: idle 0xF0F0, frame start 0xF1xx, on-time 0xF2xx, check 0xF3cc (check byte in bits 7:0), data 0x00dd (byte in bits 7:0). Any other value is unknown.
- R2: Before lock, the window slides one bit per strobe. Lock needs SYNC_IDLES (8) idle symbols in a row at 16-bit spacing. Seven idles followed by any other symbol give no lock.
- R3: Before lock, no symbol is decoded and nothing is stored. A locked channel that receives an unknown symbol drops lock and starts hunting again.
- R4: A frame runs from frame start to check and holds at most MAX_BYTES (8) data bytes. Data symbols outside a frame are ignored.
- R5: A frame is kept when it has at least one byte and its check byte equals the XOR of its data bytes. While a frame is kept, later frame starts and their bytes are ignored.
- R6: A frame with a check mismatch, zero bytes, or more than MAX_BYTES bytes is discarded, and the next repeat of the frame is evaluated afresh.
- R7: An on-time symbol publishes a result. If a frame is kept, the status is 0 (ok), byte i of the frame sits at `out_data[8i+7:8i]`, `out_len` is the byte count, and the unused bytes read zero. Otherwise the status is 2 (data error) and `out_len` is 0.
- R8: When TIMEOUT_BITS strobes pass after the last result without an on-time symbol, a result is published. Its status is 1 (no sync) if the channel is not locked, or 3 (on-time missing) if it is locked. The count then restarts.
- R9: An on-time symbol whose last bit is exactly the TIMEOUT_BITS-th strobe wins: it gives its normal result, and no timeout result is produced.
- R10: After each result, the kept frame and any partial frame are cleared. A second on-time symbol with no new frame reports status 2.
- R11: After reset `out_valid` is 0. A result holds `out_valid` high with stable fields until `out_ready` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe: `bit_in` carries a recovered bit |
| bit_in | input | 1 | Recovered serial bit |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_status | output | 2 | 0 ok, 1 no sync, 2 data error, 3 on-time missing |
| out_data | output | 8*MAX_BYTES | Frame bytes, byte 0 in the low bits |
| out_len | output | $clog2(MAX_BYTES+1) | Number of valid bytes |

## Verification
The on-time symbol and the strobe timeout can come due together. This happens when the last bit of the on-time symbol is exactly the strobe that brings the counter to its limit. The bench provokes this case directly. It first lets a result clear the counter, then sends exactly TIMEOUT_BITS strobes whose final symbol is the on-time marker. It then judges the outcome at the port: it expects exactly one result with the data-error status, and no timeout result after that one has been taken.

// File: rtl/tref_pkg.sv
package tref_pkg;
  localparam int SYM_W = 16;
  localparam logic [15:0] IDLE_CODE  = 16'hF0F0;
  localparam logic [7:0]  TAG_START  = 8'hF1;
  localparam logic [7:0]  TAG_ONTIME = 8'hF2;
  localparam logic [7:0]  TAG_CHECK  = 8'hF3;
  localparam logic [7:0]  TAG_DATA   = 8'h00;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_NOSYNC  = 2'd1;
  localparam logic [1:0] ST_DATAERR = 2'd2;
  localparam logic [1:0] ST_NOMARK  = 2'd3;

  typedef enum logic [2:0] {
    K_IDLE, K_START, K_DATA, K_CHECK, K_ONTIME, K_BAD
  } sym_kind_e;

  function automatic sym_kind_e classify(input logic [SYM_W-1:0] s);
    sym_kind_e k;
    if (s == IDLE_CODE)               k = K_IDLE;
    else if (s[15:8] == TAG_START)    k = K_START;
    else if (s[15:8] == TAG_ONTIME)   k = K_ONTIME;
    else if (s[15:8] == TAG_CHECK)    k = K_CHECK;
    else if (s[15:8] == TAG_DATA)     k = K_DATA;
    else                              k = K_BAD;
    return k;
  endfunction
endpackage

// File: rtl/tref_deser.sv
module tref_deser
  import tref_pkg::*;
#(
  parameter int SYNC_IDLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             sym_valid,
  output logic [SYM_W-1:0] sym,
  output logic             locked
);
  localparam int BCW = $clog2(SYM_W);
  localparam int ICW = $clog2(SYNC_IDLES + 1);

  logic [SYM_W-1:0] sr_q;
  logic [SYM_W-1:0] win;
  logic             phase_q;
  logic [BCW-1:0]   bcnt_q;
  logic [ICW-1:0]   icnt_q;
  logic             boundary;

  always_comb begin
    win      = {sr_q[SYM_W-2:0], bit_in};
    boundary = phase_q && (bcnt_q == BCW'(SYM_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q      <= '0;
      phase_q   <= 1'b0;
      bcnt_q    <= '0;
      icnt_q    <= '0;
      locked    <= 1'b0;
      sym_valid <= 1'b0;
      sym       <= '0;
    end else begin
      sym_valid <= 1'b0;
      if (bit_valid) begin
        sr_q <= win;
        if (!phase_q) begin
          if (win == IDLE_CODE) begin
            phase_q <= 1'b1;
            bcnt_q  <= '0;
            icnt_q  <= ICW'(1);
          end
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
          if (boundary) begin
            if (!locked) begin
              if (win == IDLE_CODE) begin
                if (icnt_q == ICW'(SYNC_IDLES - 1)) locked <= 1'b1;
                else icnt_q <= icnt_q + 1'b1;
              end else begin
                phase_q <= 1'b0;
                icnt_q  <= '0;
              end
            end else begin
              sym_valid <= 1'b1;
              sym       <= win;
              if (classify(win) == K_BAD) begin
                locked  <= 1'b0;
                phase_q <= 1'b0;
                icnt_q  <= '0;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/tref_frame.sv
module tref_frame
  import tref_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sym_valid,
  input  logic [SYM_W-1:0]       sym,
  input  logic                   locked,
  input  logic                   clr,
  output logic                   ev_valid,
  output logic                   ev_ok,
  output logic [8*MAX_BYTES-1:0] ev_data,
  output logic [LW-1:0]          ev_len
);
  sym_kind_e   kind;
  logic [7:0]  lo;
  logic        in_frame_q;
  logic        have_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] len_q;
  logic [7:0]  acc_q;
  logic        open_new;
  logic        take_byte;

  always_comb begin
    kind      = classify(sym);
    lo        = sym[7:0];
    open_new  = sym_valid && (kind == K_START) && !have_q;
    take_byte = sym_valid && (kind == K_DATA) && in_frame_q &&
                (cnt_q != LW'(MAX_BYTES));
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                b_q <= '0;
      else if (open_new)                         b_q <= '0;
      else if (take_byte && cnt_q == LW'(g))     b_q <= lo;
    end
    assign ev_data[8*g +: 8] = b_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      have_q     <= 1'b0;
      cnt_q      <= '0;
      len_q      <= '0;
      acc_q      <= '0;
      ev_valid   <= 1'b0;
      ev_ok      <= 1'b0;
      ev_len     <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (sym_valid) begin
        case (kind)
          K_START: if (!have_q) begin
            in_frame_q <= 1'b1;
            cnt_q      <= '0;
            acc_q      <= '0;
          end
          K_DATA: if (in_frame_q) begin
            if (cnt_q == LW'(MAX_BYTES)) in_frame_q <= 1'b0;
            else begin
              acc_q <= acc_q ^ lo;
              cnt_q <= cnt_q + 1'b1;
            end
          end
          K_CHECK: if (in_frame_q) begin
            in_frame_q <= 1'b0;
            if (lo == acc_q && cnt_q != '0) begin
              have_q <= 1'b1;
              len_q  <= cnt_q;
            end
          end
          K_ONTIME: begin
            ev_valid   <= 1'b1;
            ev_ok      <= have_q;
            ev_len     <= have_q ? len_q : '0;
            have_q     <= 1'b0;
            in_frame_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (!locked) in_frame_q <= 1'b0;
      if (clr) begin
        have_q     <= 1'b0;
        in_frame_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tref_report.sv
module tref_report
  import tref_pkg::*;
#(
  parameter int MAX_BYTES    = 8,
  parameter int TIMEOUT_BITS = 4096,
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int CW = $clog2(TIMEOUT_BITS + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_valid,
  input  logic                   sym_valid,
  input  logic [SYM_W-1:0]       sym,
  input  logic                   locked,
  input  logic                   ev_valid,
  input  logic                   ev_ok,
  input  logic [8*MAX_BYTES-1:0] ev_data,
  input  logic [LW-1:0]          ev_len,
  input  logic                   out_ready,
  output logic                   tmo_clr,
  output logic                   out_valid,
  output logic [1:0]             out_status,
  output logic [8*MAX_BYTES-1:0] out_data,
  output logic [LW-1:0]          out_len
);
  logic [CW-1:0] cnt_q;
  logic          pend;
  logic          fire;

  always_comb begin
    pend = sym_valid && (classify(sym) == K_ONTIME);
    fire = (cnt_q >= CW'(TIMEOUT_BITS)) && !pend && !ev_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tmo_clr <= 1'b0;
    end else begin
      tmo_clr <= fire;
      if (ev_valid || fire) cnt_q <= '0;
      else if (bit_valid && cnt_q < CW'(TIMEOUT_BITS + 1)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_status <= ST_OK;
      out_data   <= '0;
      out_len    <= '0;
    end else if (ev_valid) begin
      out_valid  <= 1'b1;
      out_status <= ev_ok ? ST_OK : ST_DATAERR;
      out_data   <= ev_ok ? ev_data : '0;
      out_len    <= ev_len;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_status <= locked ? ST_NOMARK : ST_NOSYNC;
      out_data   <= '0;
      out_len    <= '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/tref_rx_chan.sv
module tref_rx_chan
  import tref_pkg::*;
#(
  parameter int SYNC_IDLES   = 8,
  parameter int MAX_BYTES    = 8,
  parameter int TIMEOUT_BITS = 4096,
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_valid,
  input  logic                   bit_in,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [1:0]             out_status,
  output logic [8*MAX_BYTES-1:0] out_data,
  output logic [LW-1:0]          out_len
);
  logic                   sym_valid;
  logic [SYM_W-1:0]       sym;
  logic                   locked;
  logic                   tmo_clr;
  logic                   ev_valid;
  logic                   ev_ok;
  logic [8*MAX_BYTES-1:0] ev_data;
  logic [LW-1:0]          ev_len;

  tref_deser #(.SYNC_IDLES(SYNC_IDLES)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .sym_valid(sym_valid), .sym(sym), .locked(locked)
  );

  tref_frame #(.MAX_BYTES(MAX_BYTES)) u_frame (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
    .locked(locked), .clr(tmo_clr), .ev_valid(ev_valid), .ev_ok(ev_ok),
    .ev_data(ev_data), .ev_len(ev_len)
  );

  tref_report #(.MAX_BYTES(MAX_BYTES), .TIMEOUT_BITS(TIMEOUT_BITS)) u_report (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .sym_valid(sym_valid),
    .sym(sym), .locked(locked), .ev_valid(ev_valid), .ev_ok(ev_ok),
    .ev_data(ev_data), .ev_len(ev_len), .out_ready(out_ready),
    .tmo_clr(tmo_clr), .out_valid(out_valid), .out_status(out_status),
    .out_data(out_data), .out_len(out_len)
  );
endmodule

// File: rtl/tref_rx_chan_chk.sv
module tref_rx_chan_chk #(
  parameter int MAX_BYTES = 8,
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [1:0]             out_status,
  input logic [8*MAX_BYTES-1:0] out_data,
  input logic [LW-1:0]          out_len,
  input logic                   sym_valid,
  input logic                   locked,
  input logic                   ev_valid
);
  function automatic logic [8*MAX_BYTES-1:0] keep_mask(input logic [LW-1:0] n);
    logic [8*MAX_BYTES-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_BYTES; i++)
      if (LW'(i) < n) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  assert_hold_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_ok_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == 2'd0 |-> out_len != '0 && out_len <= LW'(MAX_BYTES));

  assert_ok_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status == 2'd0 |-> (out_data & ~keep_mask(out_len)) == '0);

  assert_sym_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> $past(locked));

  assert_event_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> out_valid);
endmodule

bind tref_rx_chan tref_rx_chan_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_status(out_status), .out_data(out_data), .out_len(out_len),
  .sym_valid(sym_valid), .locked(locked), .ev_valid(ev_valid)
);

// File: tb/tref_rx_chan_tb_top.sv
module tref_rx_chan_tb_top;
  localparam int T  = 1024;
  localparam int MB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  out_status;
  logic [63:0] out_data;
  logic [3:0]  out_len;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tref_rx_chan #(.SYNC_IDLES(8), .MAX_BYTES(MB), .TIMEOUT_BITS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_status(out_status),
    .out_data(out_data), .out_len(out_len)
  );

  // mode: 0 good, 1 bad then good, 2 good then different good,
  //       3 bad only, 4 nine bytes, 5 no frame, 6 empty frame
  typedef struct packed {
    logic [2:0]  mode;
    logic [3:0]  n;
    logic [63:0] data;
    logic [1:0]  st;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd0, 4'd3, 64'h0000_0000_0033_2211, 2'd0},
    '{3'd0, 4'd8, 64'h8877_6655_4433_2211, 2'd0},
    '{3'd1, 4'd2, 64'h0000_0000_0000_BEEF, 2'd0},
    '{3'd2, 4'd4, 64'h0000_0000_0403_0201, 2'd0},
    '{3'd3, 4'd5, 64'h0000_00A5_5A3C_C30F, 2'd2},
    '{3'd4, 4'd8, 64'h0102_0304_0506_0708, 2'd2},
    '{3'd5, 4'd0, 64'h0,                   2'd2},
    '{3'd6, 4'd0, 64'h0,                   2'd2},
    '{3'd0, 4'd1, 64'h0,                   2'd0}
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_in = b;
    @(negedge clk); bit_valid = 1'b0;
  endtask

  task automatic send_sym(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_idles(input int n);
    for (int i = 0; i < n; i++) send_sym(16'hF0F0);
  endtask

  task automatic send_frame(input int n, input logic [63:0] d, input bit corrupt, input bit extra);
    logic [7:0] x;
    x = 8'h00;
    send_sym(16'hF100);
    for (int i = 0; i < n; i++) begin
      send_sym({8'h00, d[8*i +: 8]});
      x ^= d[8*i +: 8];
    end
    if (extra) begin
      send_sym(16'h0055);
      x ^= 8'h55;
    end
    send_sym({8'hF3, x ^ (corrupt ? 8'h01 : 8'h00)});
  endtask

  function automatic logic [63:0] lmask(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) if (i < n) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic expect_report(input string rq, input logic [1:0] st,
                               input logic [3:0] len, input logic [63:0] data);
    bit got;
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (out_valid) begin got = 1'b1; break; end
    end
    chk({rq, " result present"}, 64'(got), 64'd1);
    if (got) begin
      chk({rq, " status"}, 64'(out_status), 64'(st));
      chk({rq, " length"}, 64'(out_len), 64'(len));
      if (st == 2'd0) chk({rq, " data"}, out_data, data);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R11 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R8: unsynced frame traffic is not stored; timeout reports no sync
    send_sym(16'hF100); send_sym(16'h0011); send_sym(16'hF311); send_sym(16'hF200);
    send_zeros(T - 64);
    expect_report("R8 no-sync timeout", 2'd1, 4'd0, 64'd0);

    // R2: seven idles do not lock
    send_idles(7); send_sym(16'hF200);
    send_zeros(T - 128);
    expect_report("R2 seven idles no lock", 2'd1, 4'd0, 64'd0);

    // R2 R3: eight idles lock; nothing from before lock is stored
    send_idles(8); send_sym(16'hF200);
    expect_report("R3 nothing stored pre-lock", 2'd2, 4'd0, 64'd0);

    // vector walk: R1 R4 R5 R6 R7
    for (int v = 0; v < 9; v++) begin
      vec_t e;
      e = VECS[v];
      send_idles(2);
      send_sym(16'h00AA);  // R4 stray byte outside a frame
      case (e.mode)
        3'd0: send_frame(e.n, e.data, 1'b0, 1'b0);
        3'd1: begin send_frame(e.n, e.data, 1'b1, 1'b0); send_frame(e.n, e.data, 1'b0, 1'b0); end
        3'd2: begin send_frame(e.n, e.data, 1'b0, 1'b0); send_frame(e.n, ~e.data, 1'b0, 1'b0); end
        3'd3: send_frame(e.n, e.data, 1'b1, 1'b0);
        3'd4: send_frame(8, e.data, 1'b0, 1'b1);
        3'd6: send_frame(0, e.data, 1'b0, 1'b0);
        default: ;
      endcase
      send_sym(16'hF200);
      expect_report($sformatf("R5 R6 R7 vector %0d", v), e.st,
                    (e.st == 2'd0) ? e.n : 4'd0, e.data & lmask(int'(e.n)));
    end

    // R10: a second marker after a published frame finds nothing
    send_frame(2, 64'h0000_0000_0000_7766, 1'b0, 1'b0);
    send_sym(16'hF201);
    expect_report("R10 frame published", 2'd0, 4'd2, 64'h7766);
    send_sym(16'hF202);
    expect_report("R10 cleared after result", 2'd2, 4'd0, 64'd0);

    // R9: marker's last bit is exactly the limit strobe
    send_idles(T/16 - 1); send_sym(16'hF200);
    expect_report("R9 marker at limit", 2'd2, 4'd0, 64'd0);
    repeat (40) @(negedge clk);
    chk("R9 no extra timeout result", 64'(out_valid), 64'd0);

    // R8: locked, no marker
    send_idles(T/16);
    expect_report("R8 marker missing", 2'd3, 4'd0, 64'd0);

    // R11: result holds under back-pressure
    send_frame(3, 64'h0000_0000_00C1_B2A3, 1'b0, 1'b0);
    send_sym(16'hF200);
    repeat (60) @(negedge clk);
    chk("R11 held valid", 64'(out_valid), 64'd1);
    chk("R11 held data", out_data, 64'h00C1_B2A3);
    repeat (10) @(negedge clk);
    chk("R11 still held", 64'(out_len), 64'd3);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R11 released", 64'(out_valid), 64'd0);

    // R3: unknown symbol drops lock; following marker not decoded
    send_sym(16'h1234); send_sym(16'hF200);
    send_zeros(T - 32);
    expect_report("R3 unknown drops lock", 2'd1, 4'd0, 64'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule